// File: doc/BRIEF.md
# Sliding Register Window File

This block is the integer register file of a processor whose procedure calls shift a window over a larger physical array rather than saving registers. The datapath always addresses 32 architectural registers with 5-bit numbers, through two combinational read ports and one clocked write port. The eight lowest registers are shared by every procedure. Registers 8 to 15 hold the values a procedure received, 16 to 23 are its private scratch, and 24 to 31 carry values towards the procedure it calls next.

On a call strobe the window moves by one step. The caller's registers 24 to 31 become the callee's registers 8 to 15 without copying anything, and the callee gets a fresh set of registers 16 to 23. On a return strobe the window moves back. What the callee left in its registers 8 to 15 then appears to the caller in registers 24 to 31. The windowed part of the array is a ring of `NWIN` slots of 16 registers. A call that would make the newest window's outgoing slot overlap the oldest live window's incoming slot raises an overflow flag. A return from the outermost window raises an underflow flag. In both cases the window stays where it is. Moving windows to and from memory is left to the surrounding system.

Top module: `rwin_regfile`

## Requirements
- R1: A read port returns, in the same cycle, the last value written to the addressed architectural register under the current window. Writes land on the rising clock edge.
- R2: After an accepted call, the values the caller held in registers 24–31 read back from registers 8–15.
- R3: After an accepted return, the values the callee held in registers 8–15 read back from registers 24–31.
- R4: Registers 16–23 are private to each window. The caller's locals hold their values across a call and the matching return.
- R5: Registers 0–7 give the same storage whatever the window position.
- R6: A call strobe while the call depth is `NWIN`−2 is refused. `ovf` is high for exactly the following cycle, and the register mapping is unchanged.
- R7: A return strobe at call depth 0 is refused. `unf` is high for exactly the following cycle, and the register mapping is unchanged.
- R8: When the write port and a read port name the same register in the same cycle, the read returns the data being written.
- R9: Call and return strobes asserted together have no effect: no flag is raised and the mapping stays put.
- R10: Synchronous reset sets the call depth and window position to 0 and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register to write |
| wr_data | input | DW | Write data |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | DW | Read port A data |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | DW | Read port B data |
| ovf_o | output | 1 | Call refused: window ring full (one-cycle pulse) |
| unf_o | output | 1 | Return refused: already outermost (one-cycle pulse) |

## Verification
The assertions assume that the strobes and write controls are known, never X, in every cycle after reset. They also assume that a write in the same cycle as a call or return is meant for the mapping in force before the edge. The stimulus holds every control at a defined level from time zero, including during reset. It mixes directed call/return chains that reach both depth limits with random traffic, and that traffic includes simultaneous strobes and writes issued alongside window moves.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int ARCH_AW   = 5;
    localparam int GROUP_SZ  = 8;
    localparam int GROUP_AW  = 3;
    localparam int WIN_SLOTS = 16;

    typedef enum logic [1:0] {
        CLS_GLOBAL = 2'd0,
        CLS_IN     = 2'd1,
        CLS_LOCAL  = 2'd2,
        CLS_OUT    = 2'd3
    } reg_cls_e;

    typedef enum logic [1:0] {
        WOP_NONE = 2'd0,
        WOP_CALL = 2'd1,
        WOP_RET  = 2'd2
    } win_op_e;

    function automatic reg_cls_e classify(input logic [ARCH_AW-1:0] arch);
        case (arch[4:3])
            2'd0:    return CLS_GLOBAL;
            2'd1:    return CLS_IN;
            2'd2:    return CLS_LOCAL;
            default: return CLS_OUT;
        endcase
    endfunction

    function automatic win_op_e decode_op(input logic call, input logic ret);
        if (call && !ret) return WOP_CALL;
        if (ret && !call) return WOP_RET;
        return WOP_NONE;
    endfunction

endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WPW  = 3,
    parameter int PAW  = 7
) (
    input  logic [WPW-1:0]      wp,
    input  logic [ARCH_AW-1:0]  arch,
    output logic                is_glob,
    output logic [GROUP_AW-1:0] gidx,
    output logic [PAW-1:0]      phys
);
    reg_cls_e       cls;
    logic [WPW-1:0] wnext;

    always_comb begin
        cls     = classify(arch);
        wnext   = (wp == WPW'(NWIN - 1)) ? '0 : wp + 1'b1;
        gidx    = arch[GROUP_AW-1:0];
        is_glob = 1'b0;
        phys    = '0;
        case (cls)
            CLS_GLOBAL: is_glob = 1'b1;
            CLS_IN:     phys = {wp,    1'b0, arch[GROUP_AW-1:0]};
            CLS_LOCAL:  phys = {wp,    1'b1, arch[GROUP_AW-1:0]};
            default:    phys = {wnext, 1'b0, arch[GROUP_AW-1:0]};
        endcase
    end
endmodule

// File: rtl/rwin_ctl.sv
module rwin_ctl
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WPW  = 3,
    parameter int DPW  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           call_i,
    input  logic           ret_i,
    output logic [WPW-1:0] wp,
    output logic [DPW-1:0] depth,
    output logic           ovf,
    output logic           unf
);
    win_op_e op;
    logic    at_top;
    logic    at_bot;

    always_comb begin
        op     = decode_op(call_i, ret_i);
        at_top = (depth == DPW'(NWIN - 2));
        at_bot = (depth == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            depth <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            unf <= 1'b0;
            case (op)
                WOP_CALL: begin
                    if (at_top) begin
                        ovf <= 1'b1;
                    end else begin
                        wp    <= (wp == WPW'(NWIN - 1)) ? '0 : wp + 1'b1;
                        depth <= depth + 1'b1;
                    end
                end
                WOP_RET: begin
                    if (at_bot) begin
                        unf <= 1'b1;
                    end else begin
                        wp    <= (wp == '0) ? WPW'(NWIN - 1) : wp - 1'b1;
                        depth <= depth - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rwin_bank.sv
module rwin_bank #(
    parameter int AW  = 3,
    parameter int DW  = 32,
    parameter int NRD = 2
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar rp = 0; rp < NRD; rp++) begin : g_rd
        always_comb begin
            if (we && (waddr == raddr[rp])) rdata[rp] = wdata;
            else                            rdata[rp] = mem[raddr[rp]];
        end
    end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               call_i,
    input  logic               ret_i,
    input  logic               wr_en,
    input  logic [ARCH_AW-1:0] wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [ARCH_AW-1:0] rd_a_addr,
    output logic [DW-1:0]      rd_a_data,
    input  logic [ARCH_AW-1:0] rd_b_addr,
    output logic [DW-1:0]      rd_b_data,
    output logic               ovf_o,
    output logic               unf_o
);
    localparam int WPW   = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int DPW   = WPW;
    localparam int PAW   = WPW + 4;
    localparam int NPORT = 3;
    localparam int NRD   = 2;

    logic [WPW-1:0] wp_q;
    logic [DPW-1:0] depth_q;

    logic [NPORT-1:0][ARCH_AW-1:0]  arch_sel;
    logic [NPORT-1:0]               is_glob;
    logic [NPORT-1:0][GROUP_AW-1:0] gidx;
    logic [NPORT-1:0][PAW-1:0]      phys;

    logic [NRD-1:0][PAW-1:0]        win_raddr;
    logic [NRD-1:0][GROUP_AW-1:0]   glb_raddr;
    logic [NRD-1:0][DW-1:0]         win_rdata;
    logic [NRD-1:0][DW-1:0]         glb_rdata;

    rwin_ctl #(.NWIN(NWIN), .WPW(WPW), .DPW(DPW)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .call_i (call_i),
        .ret_i  (ret_i),
        .wp     (wp_q),
        .depth  (depth_q),
        .ovf    (ovf_o),
        .unf    (unf_o)
    );

    assign arch_sel[0] = wr_addr;
    assign arch_sel[1] = rd_a_addr;
    assign arch_sel[2] = rd_b_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwin_map #(.NWIN(NWIN), .WPW(WPW), .PAW(PAW)) u_map (
            .wp      (wp_q),
            .arch    (arch_sel[p]),
            .is_glob (is_glob[p]),
            .gidx    (gidx[p]),
            .phys    (phys[p])
        );
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rsel
        assign win_raddr[r] = phys[r+1];
        assign glb_raddr[r] = gidx[r+1];
    end

    rwin_bank #(.AW(PAW), .DW(DW), .NRD(NRD)) u_win (
        .clk   (clk),
        .we    (wr_en && !is_glob[0]),
        .waddr (phys[0]),
        .wdata (wr_data),
        .raddr (win_raddr),
        .rdata (win_rdata)
    );

    rwin_bank #(.AW(GROUP_AW), .DW(DW), .NRD(NRD)) u_glb (
        .clk   (clk),
        .we    (wr_en && is_glob[0]),
        .waddr (gidx[0]),
        .wdata (wr_data),
        .raddr (glb_raddr),
        .rdata (glb_rdata)
    );

    assign rd_a_data = is_glob[1] ? glb_rdata[0] : win_rdata[0];
    assign rd_b_data = is_glob[2] ? glb_rdata[1] : win_rdata[1];
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    parameter int WPW  = 3,
    parameter int DPW  = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           call_i,
    input logic           ret_i,
    input logic           wr_en,
    input logic [4:0]     wr_addr,
    input logic [DW-1:0]  wr_data,
    input logic [4:0]     rd_a_addr,
    input logic [DW-1:0]  rd_a_data,
    input logic [4:0]     rd_b_addr,
    input logic [DW-1:0]  rd_b_data,
    input logic           ovf_o,
    input logic           unf_o,
    input logic [WPW-1:0] wp,
    input logic [DPW-1:0] depth
);
    // R6: refused call produces the flag one cycle later
    a_r6_ovf_on_full_call: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i && depth == DPW'(NWIN - 2)) |=> ovf_o);

    // R6: window position frozen across a refused call
    a_r6_ovf_holds_window: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i && depth == DPW'(NWIN - 2)) |=> (wp == $past(wp)));

    // R7: refused return produces the flag one cycle later, window frozen
    a_r7_unf_on_root_return: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && depth == '0) |=> (unf_o && wp == $past(wp)));

    // R6 / R7: the two refusal flags never coincide
    a_r6_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o));

    // R2: an accepted call advances the window by one slot around the ring
    a_r2_call_advances: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i && depth != DPW'(NWIN - 2)) |=>
        (wp == (($past(wp) == WPW'(NWIN - 1)) ? '0 : $past(wp) + 1'b1)));

    // R9: simultaneous strobes leave the window and flags alone
    a_r9_both_strobes_idle: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |=> (!ovf_o && !unf_o && $stable(wp) && $stable(depth)));

    // R8: write-first bypass on both read ports
    a_r8_bypass_port_a: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == rd_a_addr) |-> (rd_a_data == wr_data));

    a_r8_bypass_port_b: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == rd_b_addr) |-> (rd_b_data == wr_data));

    // R10: the cycle after reset starts at the outermost window, no flags
    a_r10_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (depth == '0 && wp == '0 && !ovf_o && !unf_o));
endmodule

bind rwin_regfile rwin_regfile_chk #(
    .NWIN (NWIN),
    .DW   (DW),
    .WPW  (WPW),
    .DPW  (DPW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (rd_b_addr),
    .rd_b_data (rd_b_data),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o),
    .wp        (wp_q),
    .depth     (depth_q)
);

// File: tb/sim_rwin_regfile.sv
`timescale 1ns/1ps
module sim_rwin_regfile;
    localparam int NW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          call_i = 1'b0, ret_i = 1'b0, wr_en = 1'b0;
    logic [4:0]    wr_addr = '0, rd_a_addr = '0, rd_b_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          ovf_o, unf_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    rwin_regfile #(.NWIN(NW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // Behavioural model: a call chain of argument sets and local sets.
    // args[k] is what frame k received; frame k's outgoing set is args[k+1].
    int            dep = 0;
    logic [DW-1:0] glob [8];
    bit            glob_v [8];
    logic [DW-1:0] args [0:9][8];
    bit            args_v [0:9][8];
    logic [DW-1:0] locs [0:9][8];
    bit            locs_v [0:9][8];
    bit            exp_ovf = 0, exp_unf = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string cls_tag(input logic [4:0] a);
        case (a[4:3])
            2'd0:    return "R5";
            2'd1:    return "R2";
            2'd2:    return "R4";
            default: return "R3";
        endcase
    endfunction

    function automatic bit model_read(input logic [4:0] a, output logic [DW-1:0] v);
        v = '0;
        if (wr_en && wr_addr == a) begin v = wr_data; return 1'b1; end
        case (a[4:3])
            2'd0: begin v = glob[a[2:0]];          return glob_v[a[2:0]]; end
            2'd1: begin v = args[dep][a[2:0]];     return args_v[dep][a[2:0]]; end
            2'd2: begin v = locs[dep][a[2:0]];     return locs_v[dep][a[2:0]]; end
            default: begin v = args[dep+1][a[2:0]]; return args_v[dep+1][a[2:0]]; end
        endcase
    endfunction

    task automatic check_port(input logic [4:0] a, input logic [DW-1:0] act, input string ovr);
        logic [DW-1:0] e;
        string t;
        if (model_read(a, e)) begin
            t = (ovr != "") ? ovr : ((wr_en && wr_addr == a) ? "R8" : cls_tag(a));
            chk(act === e, t, act, e);
        end
    endtask

    // One clock: drive at negedge, check after settling, update model at posedge.
    task automatic cyc(input bit c, input bit r, input bit we, input logic [4:0] wa,
                       input logic [DW-1:0] wd, input logic [4:0] ra, input logic [4:0] rb,
                       input string ovr);
        call_i = c; ret_i = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb;
        #2;
        check_port(ra, rd_a_data, ovr);
        check_port(rb, rd_b_data, "");
        chk(ovf_o === exp_ovf, (c && r) ? "R9" : "R6", {31'b0, ovf_o}, {31'b0, exp_ovf});
        chk(unf_o === exp_unf, (c && r) ? "R9" : "R7", {31'b0, unf_o}, {31'b0, exp_unf});
        @(posedge clk);
        if (we) begin
            case (wa[4:3])
                2'd0: begin glob[wa[2:0]] = wd;          glob_v[wa[2:0]] = 1; end
                2'd1: begin args[dep][wa[2:0]] = wd;     args_v[dep][wa[2:0]] = 1; end
                2'd2: begin locs[dep][wa[2:0]] = wd;     locs_v[dep][wa[2:0]] = 1; end
                default: begin args[dep+1][wa[2:0]] = wd; args_v[dep+1][wa[2:0]] = 1; end
            endcase
        end
        exp_ovf = 0; exp_unf = 0;
        if (c && !r) begin
            if (dep == NW - 2) exp_ovf = 1;
            else begin
                dep++;
                for (int i = 0; i < 8; i++) begin
                    locs_v[dep][i] = 0;
                    args_v[dep+1][i] = 0;
                end
            end
        end else if (r && !c) begin
            if (dep == 0) exp_unf = 1;
            else dep--;
        end
        @(negedge clk);
    endtask

    task automatic idle_read(input logic [4:0] ra, input string ovr);
        cyc(0, 0, 0, 5'd0, '0, ra, 5'd0, ovr);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < 10; k++)
            for (int i = 0; i < 8; i++) begin
                args_v[k][i] = 0; locs_v[k][i] = 0;
            end
        for (int i = 0; i < 8; i++) glob_v[i] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R10: flags clear after reset
        chk(ovf_o === 1'b0, "R10", {31'b0, ovf_o}, 32'd0);
        chk(unf_o === 1'b0, "R10", {31'b0, unf_o}, 32'd0);
        @(negedge clk);

        // R1: basic write then read back next cycle
        cyc(0, 0, 1, 5'd20, 32'h1111_0020, 5'd0, 5'd0, "");
        idle_read(5'd20, "R1");
        // R5 setup: global
        cyc(0, 0, 1, 5'd3, 32'h6000_0003, 5'd0, 5'd0, "");
        // Outgoing arguments of the root frame
        for (int i = 24; i < 32; i++)
            cyc(0, 0, 1, 5'(i), 32'hA000_0000 + i, 5'd0, 5'd0, "");
        cyc(0, 0, 1, 5'd16, 32'hC0C0_0000, 5'd0, 5'd0, "");
        // R2: call, then incoming arguments match
        cyc(1, 0, 0, 5'd0, '0, 5'd0, 5'd0, "");
        for (int i = 8; i < 16; i++) idle_read(5'(i), "R2");
        idle_read(5'd3, "R5");
        // callee writes a return value and its own local
        cyc(0, 0, 1, 5'd8, 32'hBEEF_0008, 5'd0, 5'd0, "");
        cyc(0, 0, 1, 5'd16, 32'hC0C0_0001, 5'd0, 5'd0, "");
        // R3 / R4: return, then caller sees result and intact local
        cyc(0, 1, 0, 5'd0, '0, 5'd0, 5'd0, "");
        idle_read(5'd24, "R3");
        idle_read(5'd16, "R4");
        // R7: return at the outermost frame is refused
        cyc(0, 1, 0, 5'd0, '0, 5'd0, 5'd0, "");
        idle_read(5'd16, "R7");
        idle_read(5'd25, "R7");
        // R6: call down to the limit, then one more
        for (int d = 0; d < NW - 2; d++) begin
            cyc(0, 0, 1, 5'd24, 32'hD000_0000 + d, 5'd0, 5'd0, "");
            cyc(1, 0, 0, 5'd0, '0, 5'd0, 5'd0, "");
        end
        cyc(0, 0, 1, 5'd17, 32'h1700_0017, 5'd0, 5'd0, "");
        cyc(1, 0, 0, 5'd0, '0, 5'd8, 5'd0, "");
        idle_read(5'd8, "R6");
        idle_read(5'd17, "R6");
        // R9: both strobes at once
        cyc(1, 1, 0, 5'd0, '0, 5'd8, 5'd3, "");
        idle_read(5'd8, "R9");
        idle_read(5'd17, "R9");
        // R8: same-cycle write and read on both ports
        cyc(0, 0, 1, 5'd12, 32'h8888_0012, 5'd12, 5'd12, "R8");
        cyc(0, 0, 1, 5'd5, 32'h8888_0005, 5'd5, 5'd5, "R8");
        // unwind
        for (int d = 0; d < NW - 2; d++) cyc(0, 1, 0, 5'd0, '0, 5'd24, 5'd3, "");

        // Random traffic compared against the model every cycle
        for (int n = 0; n < 1500; n++) begin
            int  roll = $urandom_range(0, 99);
            bit  c = (roll < 12) || (roll >= 95);
            bit  r = (roll >= 12 && roll < 24) || (roll >= 95);
            bit  we = $urandom_range(0, 1) == 1;
            cyc(c, r, we, 5'($urandom_range(0, 31)), $urandom(),
                5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)), "");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule